// File: doc/BRIEF.md
# Byte/Word Integer ALU with Flag Register

This block is the integer arithmetic and logic stage of a 16-bit processor datapath. Each accepted operation takes two operands, works at byte or word width, and registers both the result and a new set of six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Add-with-carry and subtract-with-borrow take their carry-in from the stored carry flag, so multi-word arithmetic chains across consecutive operations.

The flag register also holds three control flags: trap, interrupt enable and direction. Only dedicated set and clear command inputs change them. Arithmetic never does. Direction is consumed by string address stepping elsewhere in the core: 1 means addresses count down and 0 means they count up. Compare runs a subtraction to produce flags but leaves the result register untouched.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result_q` and every bit of `flags_q` are cleared to zero, and they are zero on the first cycle after reset.
- R2: Opcode 0 (add) and opcode 1 (add with carry) write the sum of the operands at the selected width to `result_q` one cycle after `op_valid`. Opcode 1 also adds the stored carry flag. Carry is set on a carry out of the top bit of the selected width.
- R3: Opcode 2 (subtract) and opcode 3 (subtract with borrow) write `a - b` to the result. Opcode 3 also subtracts the stored carry. Carry is set when a borrow occurs out of the top bit.
- R4: Overflow is set when exactly one of the carry into the top bit and the carry out of the top bit occurs, and is clear otherwise. For example, byte add 50h + 32h = 82h sets overflow.
- R5: Auxiliary carry is the carry (add) or borrow (subtract) out of bit 3.
- R6: Sign is the top bit of the result at the selected width. Zero is set when every result bit at that width is 0. Parity is set when the low 8 result bits hold an even number of ones.
- R7: Opcodes 4, 5 and 6 give bitwise AND, OR and XOR. They clear carry, overflow and auxiliary carry.
- R8: Opcode 7 (compare) sets the status flags exactly as subtract would, and `result_q` keeps its previous value.
- R9: With `word_sel` low, only operand bits 7:0 take part in the operation, and `result_q[15:8]` is written as zero.
- R10: Bits 0, 1 and 2 of `ctl_set` set trap, interrupt enable and direction respectively, and the matching bits of `ctl_clr` clear them. Set wins over clear, and commands act whether or not `op_valid` is high. No operation changes these flags.
- R11: On a cycle with `op_valid` low, `result_q` and the six status flags hold their values.
- R12: The bits of `flags_q` are: 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow, 6 trap, 7 interrupt enable, 8 direction. Bits 15:9 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the operation on this edge |
| op_code | input | 3 | Operation select (see R2, R3, R7, R8) |
| word_sel | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| ctl_set | input | 3 | Set commands for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear commands for trap, interrupt enable, direction |
| result_q | output | 16 | Registered result |
| flags_q | output | 16 | Registered flag word |

## Verification
The byte-width sweep covers every pairing of sixteen operand values spread evenly over 00h..FFh, under all eight opcodes. It crosses both nibble and byte boundaries, so carry, borrow, auxiliary carry and signed overflow are each seen both set and clear. The upper operand bytes carry noise in this sweep, which shows that byte mode ignores them. A word-width sweep of repeating-nibble patterns with their midpoints flipped exercises sign and zero at bit 15 and the flags carried from one operation into add-with-carry and subtract-with-borrow. Directed cases pin the 50h + 32h overflow, the 7FFFh/8000h word boundaries and the set-over-clear rule of the control commands. Pseudo-random idle cycles and control commands placed between operations tell apart hold behaviour, command behaviour and arithmetic updates.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTL_N  = 3;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  // flag word bit positions
  localparam int unsigned FB_CRY = 0;
  localparam int unsigned FB_PAR = 1;
  localparam int unsigned FB_AUX = 2;
  localparam int unsigned FB_ZRO = 3;
  localparam int unsigned FB_SGN = 4;
  localparam int unsigned FB_OVF = 5;
  localparam int unsigned FB_TRP = 6;
  localparam int unsigned FB_INT = 7;
  localparam int unsigned FB_DIR = 8;
  localparam int unsigned FLAG_USED = FB_DIR + 1;

  // packed so that cry lands at bit 0
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } stat_t;

  function automatic logic op_is_logic(alu_op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR};
  endfunction

endpackage

// File: rtl/alu_lane.sv
module alu_lane
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cry_o,
  output logic         aux_o,
  output logic         ovf_o
);

  localparam int unsigned EXT_W = W + 1;
  localparam int unsigned TOP   = W - 1;

  logic             is_sub;
  logic             use_cin;
  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] ext_c;
  logic [EXT_W-1:0] arith;
  logic             into_top;
  logic             out_of_nib;

  always_comb begin
    is_sub  = op_i inside {OP_SUB, OP_SBB, OP_CMP};
    use_cin = op_i inside {OP_ADC, OP_SBB};
    ext_a   = {1'b0, a_i};
    ext_b   = {1'b0, b_i};
    ext_c   = {{W{1'b0}}, use_cin & cin_i};
    arith   = is_sub ? (ext_a - ext_b - ext_c) : (ext_a + ext_b + ext_c);
    // carry/borrow entering a bit = a ^ b ^ sum at that bit
    into_top   = a_i[TOP] ^ b_i[TOP] ^ arith[TOP];
    out_of_nib = a_i[4] ^ b_i[4] ^ arith[4];

    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; cry_o = 1'b0; aux_o = 1'b0; ovf_o = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; cry_o = 1'b0; aux_o = 1'b0; ovf_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ b_i; cry_o = 1'b0; aux_o = 1'b0; ovf_o = 1'b0; end
      default: begin
        res_o = arith[W-1:0];
        cry_o = arith[W];
        aux_o = out_of_nib;
        ovf_o = into_top ^ arith[W];
      end
    endcase
  end

endmodule

// File: rtl/flag_eval.sv
module flag_eval
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              word_sel_i,
  input  logic [DATA_W-1:0] byte_res_i,
  input  logic [DATA_W-1:0] word_res_i,
  input  logic [1:0]        cry_i,
  input  logic [1:0]        aux_i,
  input  logic [1:0]        ovf_i,
  output logic [DATA_W-1:0] res_o,
  output stat_t             stat_o
);

  localparam int unsigned LANE = 1;

  logic lane;

  always_comb begin
    lane        = word_sel_i;
    res_o       = word_sel_i ? word_res_i : byte_res_i;
    stat_o.cry  = cry_i[lane];
    stat_o.aux  = aux_i[lane];
    stat_o.ovf  = ovf_i[lane];
    stat_o.sgn  = word_sel_i ? res_o[DATA_W-1] : res_o[BYTE_W-1];
    stat_o.zro  = word_sel_i ? (res_o == '0) : (res_o[BYTE_W-1:0] == '0);
    stat_o.par  = ~^res_o[BYTE_W-1:0];
  end

  // R9: a byte lane result never reaches above bit 7
  always_comb begin
    if (!word_sel_i) begin
      byte_upper_chk: assert (res_o[DATA_W-1:BYTE_W] == '0 || LANE != 1)
        else $error("byte result has upper bits");
    end
  end

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import flag_alu_pkg::*;
#(
  parameter int unsigned FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  stat_t             stat_i,
  input  logic [CTL_N-1:0]  ctl_set_i,
  input  logic [CTL_N-1:0]  ctl_clr_i,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int unsigned PAD_W = FLAG_W - FLAG_USED;

  stat_t            stat_q;
  logic [CTL_N-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (op_valid_i) stat_q <= stat_i;
      ctl_q <= (ctl_q & ~ctl_clr_i) | ctl_set_i;
    end
  end

  assign flags_o = {{PAD_W{1'b0}}, ctl_q, stat_q};

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_set_i == '0 && ctl_clr_i == '0) |=> $stable(flags_o[FB_DIR:FB_TRP]))
    else $error("control flags moved without a command");

  // R10
  ctl_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_set_i != '0) |=> ((flags_o[FB_DIR:FB_TRP] & $past(ctl_set_i)) == $past(ctl_set_i)))
    else $error("set command did not take effect");

  // R11
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> $stable(flags_o[FB_OVF:FB_CRY]))
    else $error("status flags moved while idle");

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              word_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  output logic [DATA_W-1:0] result_q,
  output logic [DATA_W-1:0] flags_q
);

  localparam int unsigned LANES = 2;

  alu_op_e           op;
  logic [DATA_W-1:0] lane_res [LANES];
  logic [LANES-1:0]  lane_cry;
  logic [LANES-1:0]  lane_aux;
  logic [LANES-1:0]  lane_ovf;
  logic [DATA_W-1:0] sel_res;
  stat_t             stat_nxt;

  assign op = alu_op_e'(op_code);

  // lane 0 = byte width, lane 1 = word width
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LW = (g == 0) ? BYTE_W : DATA_W;
    logic [LW-1:0] raw;
    alu_lane #(.W(LW)) u_lane (
      .a_i   (opnd_a[LW-1:0]),
      .b_i   (opnd_b[LW-1:0]),
      .op_i  (op),
      .cin_i (flags_q[FB_CRY]),
      .res_o (raw),
      .cry_o (lane_cry[g]),
      .aux_o (lane_aux[g]),
      .ovf_o (lane_ovf[g])
    );
    assign lane_res[g] = DATA_W'(raw);
  end

  flag_eval #(.DATA_W(DATA_W)) u_eval (
    .word_sel_i (word_sel),
    .byte_res_i (lane_res[0]),
    .word_res_i (lane_res[1]),
    .cry_i      (lane_cry),
    .aux_i      (lane_aux),
    .ovf_i      (lane_ovf),
    .res_o      (sel_res),
    .stat_o     (stat_nxt)
  );

  status_flag_reg #(.FLAG_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid),
    .stat_i     (stat_nxt),
    .ctl_set_i  (ctl_set),
    .ctl_clr_i  (ctl_clr),
    .flags_o    (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) result_q <= '0;
    else if (op_valid && op != OP_CMP) result_q <= sel_res;
  end

  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_logic(op)) |=> (!flags_q[FB_CRY] && !flags_q[FB_OVF] && !flags_q[FB_AUX]))
    else $error("logic op left carry/overflow set");

  // R8
  cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_CMP) |=> $stable(result_q))
    else $error("compare wrote the result");

  // R9
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op != OP_CMP && !word_sel) |=> (result_q[DATA_W-1:BYTE_W] == '0))
    else $error("byte op wrote upper result bits");

  // R6
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op != OP_CMP) |=> (flags_q[FB_ZRO] == (result_q == '0)))
    else $error("zero flag disagrees with result");

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(result_q))
    else $error("result moved while idle");

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        word_sel = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [2:0]  ctl_set = '0;
  logic [2:0]  ctl_clr = '0;
  logic [15:0] result_q;
  logic [15:0] flags_q;

  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  logic [15:0] exp_res = '0;
  logic [5:0]  exp_st  = '0;   // {ovf,sgn,zro,aux,par,cry}
  logic [2:0]  exp_ctl = '0;   // {dir,int,trap}
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  flag_alu u_flag_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .word_sel(word_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .result_q(result_q), .flags_q(flags_q)
  );

  function automatic logic [15:0] exp_flags();
    return {7'b0, exp_ctl, exp_st};
  endfunction

  function automatic logic [15:0] step(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // arithmetic reference model
  task automatic model(input logic [2:0] op, input logic ws,
                       input logic [15:0] a, input logic [15:0] b, input logic cin,
                       output logic [15:0] r, output logic [5:0] st);
    longint w    = ws ? 16 : 8;
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint ua   = longint'(a) & mask;
    longint ub   = longint'(b) & mask;
    longint sa   = (ua >= half) ? ua - (mask + 1) : ua;
    longint sb   = (ub >= half) ? ub - (mask + 1) : ub;
    longint ci   = (op == 3'd1 || op == 3'd3) ? longint'(cin) : 0;
    longint full, sres, rr;
    logic cy, ac, ov;
    cy = 0; ac = 0; ov = 0; rr = 0;
    case (op)
      3'd0, 3'd1: begin
        full = ua + ub + ci; sres = sa + sb + ci;
        cy = (full > mask); ac = (((ua & 15) + (ub & 15) + ci) > 15);
        ov = (sres >= half) || (sres < -half); rr = full & mask;
      end
      3'd2, 3'd3, 3'd7: begin
        full = ua - ub - ci; sres = sa - sb - ci;
        cy = (full < 0); ac = ((ua & 15) < ((ub & 15) + ci));
        ov = (sres >= half) || (sres < -half); rr = full & mask;
      end
      3'd4: rr = ua & ub;
      3'd5: rr = ua | ub;
      default: rr = ua ^ ub;
    endcase
    r  = rr[15:0];
    st = {ov, ((rr >> (w - 1)) & 1) != 0, rr == 0, ac, ~^r[7:0], cy};
  endtask

  task automatic check(input string tag);
    vectors++;
    if (result_q !== exp_res || flags_q !== exp_flags()) begin
      miscompares++;
      $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
               tag, result_q, flags_q, exp_res, exp_flags());
    end
  endtask

  // drive at negedge, compare at the next negedge (one register stage)
  task automatic apply(input logic v, input logic [2:0] op, input logic ws,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] s, input logic [2:0] c, input string tag);
    logic [15:0] r;
    logic [5:0]  st;
    op_valid = v; op_code = op; word_sel = ws; opnd_a = a; opnd_b = b;
    ctl_set = s; ctl_clr = c;
    model(op, ws, a, b, exp_st[0], r, st);
    if (v) begin
      exp_st = st;
      if (op != 3'd7) exp_res = r;
    end
    exp_ctl = (exp_ctl & ~c) | s;
    @(negedge clk);
    check(tag);
  endtask

  function automatic string op_tag(logic v, logic [2:0] op);
    if (!v) return "R11 idle hold";
    case (op)
      3'd0, 3'd1: return "R2/R4/R5/R6 add";
      3'd2, 3'd3: return "R3/R4/R5/R6 sub";
      3'd7:       return "R8 compare";
      default:    return "R7 logic";
    endcase
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state");

    // R4 directed: byte 50h + 32h = 82h, overflow set
    apply(1, 3'd0, 0, 16'h0050, 16'h0032, 3'b000, 3'b000, "R4 50h+32h");
    vectors++;
    if (flags_q[5] !== 1'b1 || result_q !== 16'h0082) begin
      miscompares++;
      $display("FAIL R4: ovf=%b result=%h expected ovf=1 result=0082", flags_q[5], result_q);
    end
    // R5 nibble carry, R9 upper operand bytes ignored
    apply(1, 3'd0, 0, 16'hAB0F, 16'hCD01, 3'b000, 3'b000, "R5/R9 nibble carry");
    apply(1, 3'd2, 0, 16'hFF10, 16'h7701, 3'b000, 3'b000, "R5/R9 nibble borrow");
    // R4 word boundaries
    apply(1, 3'd0, 1, 16'h7FFF, 16'h0001, 3'b000, 3'b000, "R4 word 7FFF+1");
    apply(1, 3'd2, 1, 16'h8000, 16'h0001, 3'b000, 3'b000, "R4 word 8000-1");
    apply(1, 3'd0, 1, 16'hFFFF, 16'h0001, 3'b000, 3'b000, "R2/R6 word wrap to zero");
    apply(1, 3'd1, 1, 16'h0000, 16'h0000, 3'b000, 3'b000, "R2 adc stored carry");
    // R10 control commands and R12 layout
    apply(1, 3'd0, 0, 16'h0001, 16'h0001, 3'b111, 3'b000, "R10/R12 set all control");
    apply(1, 3'd6, 1, 16'h1234, 16'h1234, 3'b000, 3'b000, "R10 arithmetic leaves control");
    apply(0, 3'd0, 0, 16'h0000, 16'h0000, 3'b010, 3'b111, "R10 set wins over clear");
    apply(0, 3'd0, 0, 16'h0000, 16'h0000, 3'b000, 3'b010, "R10 clear interrupt");
    apply(1, 3'd7, 1, 16'h0003, 16'h0005, 3'b000, 3'b000, "R8 compare keeps result");

    // byte sweep, noisy upper bytes (R9) and random idle/commands (R10, R11)
    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          logic v;
          logic [2:0] s, c;
          lfsr = step(lfsr);
          v = (lfsr[12:10] != 3'b000);
          s = (lfsr[4:3] == 2'b00) ? lfsr[2:0] : 3'b000;
          c = (lfsr[6:5] == 2'b00) ? lfsr[9:7] : 3'b000;
          apply(v, 3'(op), 0, {lfsr[15:8], 8'(ia * 17)}, {lfsr[7:0], 8'(ib * 17)},
                s, c, op_tag(v, 3'(op)));
        end
      end
    end

    // word sweep
    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          logic [15:0] a, b;
          a = 16'(ia * 16'h1111) ^ ((ia % 2 == 1) ? 16'h0888 : 16'h0000);
          b = 16'(ib * 16'h1111) ^ ((ib % 3 == 0) ? 16'h8000 : 16'h0000);
          apply(1, 3'(op), 1, a, b, 3'b000, 3'b000, op_tag(1, 3'(op)));
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (R1..R12 run): actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule